// File: doc/BRIEF.md
# Shared-Memory Input Buffer with Per-Output Logical Queues

This block is the buffering stage of one switch input port. A single cell memory holds `DEPTH` cells. That memory is split dynamically into `N_OUT` logical FIFO queues, one for each switch output. At most one cell arrives per slot, together with its destination output. An accepted cell is linked onto the tail of its destination's queue. In the same slot, the block raises a routing request toward that output's arbiter.

The arbiters sit outside this block. Each arbiter returns a grant for its own output. A granted queue releases its oldest cell on that output's data lane in the next slot. Grants on several outputs in one slot are all served together, so a busy output never holds back cells bound elsewhere. Storage is tracked by a free map of cell slots, and each queue keeps head and tail pointers with next-links. If no slot is free when a cell arrives, the cell is discarded and counted.

Top module: `sq_shared_buffer`

## Requirements
- R1: After reset, every queue occupancy is 0, `full_o` is low, `out_valid_o` is all zero and `drop_cnt_o` is 0.
- R2: A cell accepted in a slot drives bit `in_dest_i` of `req_o` high in that same slot, and every other bit low. `req_o` is zero when no cell is accepted.
- R3: A grant on output j, given while queue j is non-empty, sets `out_valid_o[j]` after the next clock edge. It also places the oldest cell of queue j on `out_data_o[j*DATA_W +: DATA_W]`, so each queue is served in arrival order.
- R4: Grants on several non-empty queues in the same slot are all served in that slot, each on its own lane.
- R5: A grant on an empty queue has no effect. That output's valid bit stays low and the queue's occupancy is unchanged.
- R6: `full_o` is high exactly when `DEPTH` cells are stored across all queues. A cell arriving while `full_o` is high is discarded: it raises no request, leaves all occupancies unchanged and adds 1 to `drop_cnt_o`. This holds even if a grant frees a cell in the same slot.
- R7: `occ_o[j*CW +: CW]`, where CW = clog2(DEPTH+1), equals the accepted cells minus the served cells of queue j. It updates at the clock edge that ends the slot.
- R8: An arrival and a grant on the same queue in the same slot both take effect, including when the queue holds exactly one cell. The old head is delivered and the new cell becomes the head.
- R9: A cell slot freed by a grant becomes available for new arrivals in the following slot. After the buffer is drained, `DEPTH` new cells are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | A cell arrives this slot |
| in_dest_i | input | clog2(N_OUT) | Destination output of the arriving cell |
| in_data_i | input | DATA_W | Arriving cell payload |
| grant_i | input | N_OUT | Per-output grant from the output arbiters |
| req_o | output | N_OUT | Routing request, one bit per output |
| full_o | output | 1 | No free cell slot |
| out_valid_o | output | N_OUT | Cell delivered on that output lane |
| out_data_o | output | N_OUT*DATA_W | Delivered payloads, lane j at bits j*DATA_W |
| occ_o | output | N_OUT*clog2(DEPTH+1) | Per-queue occupancy |
| drop_cnt_o | output | DROP_W | Count of cells discarded on full, wrapping |

## Verification
A broken next-link or head pointer shows at the ports on the next grant to that queue: the payload comes out wrong or out of order, one slot after the grant. Grants on empty queues and grants on several queues at once are therefore issued against a shadow model of each queue. A leaked or double-used cell slot shows differently. `full_o` rises either early or late compared with the total occupancy. A slot written twice shows up as corrupted payloads later on. For this reason the bench fills the buffer, drains it and refills it, and it also runs long random traffic near the full boundary.

// File: rtl/sq_pkg.sv
package sq_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
  function automatic int unsigned cnt_w(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sq_free_map.sv
module sq_free_map #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [DEPTH-1:0] release_i,
  output logic [AW-1:0]    alloc_addr_o,
  output logic             empty_o
);
  logic [DEPTH-1:0] free_q, alloc_mask;

  // lowest free slot wins
  always_comb begin
    alloc_addr_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (free_q[i]) alloc_addr_o = AW'(i);
  end

  assign empty_o    = ~|free_q;
  assign alloc_mask = alloc_i ? (DEPTH'(1) << alloc_addr_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) free_q <= '1;
    else         free_q <= (free_q & ~alloc_mask) | release_i;
endmodule

// File: rtl/sq_lq_ctrl.sv
module sq_lq_ctrl #(
  parameter int unsigned AW = 4,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          grant_i,
  input  logic [AW-1:0] head_next_i,
  output logic          pop_o,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o,
  output logic [CW-1:0] occ_o
);
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q;

  assign pop_o  = grant_i && (occ_q != '0);
  assign head_o = head_q;
  assign tail_o = tail_q;
  assign occ_o  = occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      occ_q <= occ_q + CW'(push_i) - CW'(pop_o);
      if (push_i) tail_q <= push_addr_i;
      // new cell becomes head when queue is or becomes empty this slot
      if (push_i && (occ_q == '0 || (occ_q == CW'(1) && pop_o)))
        head_q <= push_addr_i;
      else if (pop_o)
        head_q <= head_next_i;
    end
  end
endmodule

// File: rtl/sq_shared_buffer.sv
module sq_shared_buffer #(
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DROP_W = 16
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          in_valid_i,
  input  logic [sq_pkg::idx_w(N_OUT)-1:0]               in_dest_i,
  input  logic [DATA_W-1:0]                             in_data_i,
  input  logic [N_OUT-1:0]                              grant_i,
  output logic [N_OUT-1:0]                              req_o,
  output logic                                          full_o,
  output logic [N_OUT-1:0]                              out_valid_o,
  output logic [N_OUT*DATA_W-1:0]                       out_data_o,
  output logic [N_OUT*sq_pkg::cnt_w(DEPTH)-1:0]         occ_o,
  output logic [DROP_W-1:0]                             drop_cnt_o
);
  localparam int unsigned AW = sq_pkg::idx_w(DEPTH);
  localparam int unsigned DW = sq_pkg::idx_w(N_OUT);
  localparam int unsigned CW = sq_pkg::cnt_w(DEPTH);

  logic [DATA_W-1:0] cell_mem [DEPTH];
  logic [AW-1:0]     link_mem [DEPTH];

  logic              full, dest_ok, accept;
  logic [AW-1:0]     waddr;
  logic [DEPTH-1:0]  release_mask;
  logic [N_OUT-1:0]  push_v, pop_v;
  logic [AW-1:0]     head_a [N_OUT];
  logic [AW-1:0]     tail_a [N_OUT];
  logic [CW-1:0]     occ_a  [N_OUT];
  logic [AW-1:0]     dest_tail;
  logic              dest_busy;

  assign dest_ok = {1'b0, in_dest_i} < (DW+1)'(N_OUT);
  assign accept  = in_valid_i && !full && dest_ok;
  assign full_o  = full;
  assign req_o   = push_v;

  sq_free_map #(.DEPTH(DEPTH), .AW(AW)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (accept),
    .release_i   (release_mask),
    .alloc_addr_o(waddr),
    .empty_o     (full)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_q
    assign push_v[j] = accept && (in_dest_i == DW'(j));
    sq_lq_ctrl #(.AW(AW), .CW(CW)) u_lq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_v[j]),
      .push_addr_i(waddr),
      .grant_i    (grant_i[j]),
      .head_next_i(link_mem[head_a[j]]),
      .pop_o      (pop_v[j]),
      .head_o     (head_a[j]),
      .tail_o     (tail_a[j]),
      .occ_o      (occ_a[j])
    );
    assign occ_o[j*CW +: CW] = occ_a[j];
  end

  always_comb begin
    release_mask = '0;
    dest_tail    = '0;
    dest_busy    = 1'b0;
    for (int j = 0; j < N_OUT; j++) begin
      if (pop_v[j]) release_mask[head_a[j]] = 1'b1;
      if (push_v[j]) begin
        dest_tail = tail_a[j];
        dest_busy = (occ_a[j] != '0);
      end
    end
  end

  // storage arrays carry no reset
  always_ff @(posedge clk_i) begin
    if (accept) begin
      cell_mem[waddr] <= in_data_i;
      if (dest_busy) link_mem[dest_tail] <= waddr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= '0;
      out_data_o  <= '0;
      drop_cnt_o  <= '0;
    end else begin
      out_valid_o <= pop_v;
      for (int j = 0; j < N_OUT; j++)
        if (pop_v[j]) out_data_o[j*DATA_W +: DATA_W] <= cell_mem[head_a[j]];
      if (in_valid_i && full) drop_cnt_o <= drop_cnt_o + DROP_W'(1);
    end
  end
endmodule

// File: rtl/sq_buf_chk.sv
module sq_buf_chk #(
  parameter int unsigned N_OUT  = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DROP_W = 16
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic [N_OUT-1:0]                      grant_i,
  input logic [N_OUT-1:0]                      req_o,
  input logic                                  full_o,
  input logic [N_OUT-1:0]                      out_valid_o,
  input logic [N_OUT*sq_pkg::cnt_w(DEPTH)-1:0] occ_o,
  input logic [DROP_W-1:0]                     drop_cnt_o
);
  localparam int unsigned CW = sq_pkg::cnt_w(DEPTH);

  logic [31:0]      total;
  logic [N_OUT-1:0] nonempty;

  always_comb begin
    total = '0;
    for (int j = 0; j < N_OUT; j++) begin
      total       = total + 32'(occ_o[j*CW +: CW]);
      nonempty[j] = (occ_o[j*CW +: CW] != '0);
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o)); // R2
  AST_FULL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (req_o == '0)); // R6
  AST_FULL_MATCHES_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (total == 32'(DEPTH))); // R6
  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DROP_W'(drop_cnt_o - $past(drop_cnt_o)) <= DROP_W'(1))); // R6
  AST_OUT_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_valid_o & ~$past(grant_i & nonempty)) == '0)); // R5
endmodule

bind sq_shared_buffer sq_buf_chk #(.N_OUT(N_OUT), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grant_i    (grant_i),
  .req_o      (req_o),
  .full_o     (full_o),
  .out_valid_o(out_valid_o),
  .occ_o      (occ_o),
  .drop_cnt_o (drop_cnt_o)
);

// File: tb/tb_sq_shared_buffer.sv
module tb_sq_shared_buffer;
  localparam int N = 4, L = 16, W = 8, CW = 5, DRW = 16;

  logic clk = 0, rst_ni = 0;
  logic in_valid;
  logic [1:0] in_dest;
  logic [W-1:0] in_data;
  logic [N-1:0] grant;
  logic [N-1:0] req_o, out_valid_o;
  logic full_o;
  logic [N*W-1:0] out_data_o;
  logic [N*CW-1:0] occ_o;
  logic [DRW-1:0] drop_cnt_o;

  always #2 clk = ~clk;

  sq_shared_buffer #(.N_OUT(N), .DEPTH(L), .DATA_W(W), .DROP_W(DRW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_dest_i(in_dest),
    .in_data_i(in_data), .grant_i(grant), .req_o(req_o), .full_o(full_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .occ_o(occ_o),
    .drop_cnt_o(drop_cnt_o));

  int checks = 0, errors = 0;
  bit done = 0;

  // shadow queues
  logic [W-1:0] mq [N][L];
  int mh [N], mc [N];
  int exp_drop = 0;
  logic [N-1:0] exp_valid;
  logic [W-1:0] exp_data [N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int total_cells();
    int t = 0;
    for (int j = 0; j < N; j++) t += mc[j];
    return t;
  endfunction

  // one slot; called at negedge, returns at next negedge
  task automatic step(input bit v, input int d, input logic [W-1:0] data,
                      input logic [N-1:0] g, input string tag);
    bit efull;
    logic [N-1:0] ereq;
    in_valid = v; in_dest = 2'(d); in_data = data; grant = g;
    #1;
    efull = (total_cells() == L);
    ereq  = (v && !efull) ? (N'(1) << d) : '0;
    chk(full_o == efull, "R6", "full_o", full_o, efull);
    chk(req_o == ereq, efull ? "R6" : "R2", "req_o", req_o, ereq);
    for (int j = 0; j < N; j++) begin
      exp_valid[j] = g[j] && mc[j] > 0;
      if (exp_valid[j]) begin
        exp_data[j] = mq[j][mh[j]];
        mh[j] = (mh[j] + 1) % L;
        mc[j]--;
      end
    end
    if (v && !efull) begin
      mq[d][(mh[d] + mc[d]) % L] = data;
      mc[d]++;
    end
    if (v && efull) exp_drop++;
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      chk(out_valid_o[j] == exp_valid[j], exp_valid[j] ? tag : "R5",
          $sformatf("out_valid[%0d]", j), out_valid_o[j], exp_valid[j]);
      if (exp_valid[j])
        chk(out_data_o[j*W +: W] == exp_data[j], tag,
            $sformatf("out_data[%0d]", j), out_data_o[j*W +: W], exp_data[j]);
      chk(occ_o[j*CW +: CW] == CW'(mc[j]), "R7", $sformatf("occ[%0d]", j),
          occ_o[j*CW +: CW], mc[j]);
    end
    chk(drop_cnt_o == DRW'(exp_drop), "R6", "drop_cnt", drop_cnt_o, exp_drop);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N; j++) begin mh[j] = 0; mc[j] = 0; end
    in_valid = 0; in_dest = 0; in_data = 0; grant = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid_o == '0, "R1", "out_valid", out_valid_o, 0);
    chk(occ_o == '0, "R1", "occ", occ_o, 0);
    chk(full_o == 0, "R1", "full", full_o, 0);
    chk(drop_cnt_o == '0, "R1", "drop", drop_cnt_o, 0);

    // R2, R8: same-queue read and write at occupancy 1
    step(1, 0, 8'h11, 4'b0000, "R2");
    step(1, 0, 8'h22, 4'b0001, "R8");
    step(0, 0, 8'h00, 4'b0001, "R3");
    // R5: grant to empty queues
    step(0, 0, 8'h00, 4'b1111, "R5");
    // R4: several outputs served in one slot
    step(1, 1, 8'h31, 4'b0000, "R2");
    step(1, 2, 8'h32, 4'b0000, "R2");
    step(1, 3, 8'h33, 4'b0000, "R2");
    step(1, 0, 8'h30, 4'b0000, "R2");
    step(0, 0, 8'h00, 4'b1111, "R4");
    // R6: fill, arrival while full dropped even with a same-slot grant
    for (int i = 0; i < L; i++) step(1, i % N, 8'(8'h40 + i), 4'b0000, "R6");
    step(1, 2, 8'hEE, 4'b0000, "R6");
    step(1, 1, 8'hEF, 4'b0001, "R6");
    // R9: drain then refill full depth
    for (int i = 0; i < 6; i++) step(0, 0, 8'h00, 4'b1111, "R3");
    for (int i = 0; i < L; i++) step(1, 3, 8'(8'h80 + i), 4'b0000, "R9");
    step(1, 0, 8'hAA, 4'b0000, "R9");
    for (int i = 0; i < L; i++) step(0, 0, 8'h00, 4'b1000, "R3");

    // random traffic around the full boundary
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 8) != 0;
      int d = $urandom % N;
      logic [N-1:0] g = N'($urandom) & N'($urandom);
      step(v, d, W'($urandom), g, "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule